// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

This block is a byte-addressable serial EEPROM target for a two-wire bus. It runs on a system clock, samples the bus clock and data lines through synchronisers, and turns their edges into bus events. A START opens a transfer. The slave then takes in an address byte. It answers only if the fixed device-type nibble matches and the strapped address pins agree with the bits that the selected density leaves for chip select.

The density parameter ranges from 1 Kbit to 16 Kbit. It sets how the three address bits of the address byte are shared out. Some of them are compared against the strapping pins. The rest pick a 256-byte block inside the array.

A write transfer works in two steps. The first data byte loads the word pointer. Each further byte is stored at the pointer, and the pointer then steps forward within its block. A write-protect input stops every store, but the bytes are still acknowledged. A read transfer returns bytes from the pointer MSB first, and continues for as long as the master acknowledges. Random reads use a write of the word address, followed by a repeated START.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset, and whenever no transfer is open, `sda_oe_o` is low. Bus clocking without a preceding START (SDA falling while SCL is high) is ignored.
- R2: A STOP (SDA rising while SCL is high) closes any transfer. Bytes clocked after it, with no new START, receive no acknowledge.
- R3: Address bits [7:4] must be 4'b1010. Otherwise no acknowledge is given and the slave stays silent until the next START.
- R4: With the default 4 Kbit density, address bits [3:2] are compared against `addr_pins_i[2:1]`. Bit 1 and `addr_pins_i[0]` take no part in the match. A mismatch gets no acknowledge.
- R5: The acknowledge drives SDA low during the ninth SCL pulse after a byte. It is asserted after the eighth falling edge and released after the ninth falling edge.
- R6: In a write transfer, the first data byte loads the word pointer. Each later byte is stored at the pointer, and the low 8 pointer bits then increment, wrapping from 0xFF to 0x00 inside the same block.
- R7: Address bits not used for the pin match (bit 1 at 4 Kbit) select the 256-byte block for both reads and writes. Blocks are independent.
- R8: While `wp_i` is high, write data bytes are still acknowledged, but the array is not changed.
- R9: Address bit 0 set to 1 starts a read. Data is driven MSB first and changes only while SCL is low. A master ACK continues with the next address. A NACK releases SDA until STOP or START.
- R10: After reset, every array byte reads 0xFF.
- R11: A read with no word-address phase returns the byte at the pointer left by the previous transfer. Each byte read advances the pointer by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | High pulls the data line low (open drain) |
| addr_pins_i | input | 3 | Strapped chip-select pins, bit 2 down to bit 0 |
| wp_i | input | 1 | Write protect, high blocks array updates |

## Verification
The assertions take for granted that each SCL level lasts at least four system clocks. Under that condition the two-flop synchroniser cannot merge two edges or miss one. They also take for granted that the master never issues START or STOP while the slave holds SDA low, so a data line driven by the slave only changes while SCL is low. The bench keeps each SCL half period at 16 system clocks. It moves SDA only in the middle of the low phase, except for deliberate START and STOP conditions, and it releases SDA whenever the slave owns the ninth bit or a read data bit.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_WAIT
  } ee_state_e;

  // address bits of the slave byte that act as block select
  function automatic int blk_bits(input int kbit);
    if (kbit <= 2) return 0;
    else if (kbit == 4) return 1;
    else if (kbit == 8) return 2;
    else return 3;
  endfunction

endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  assign scl_s      = scl_sh[STAGES-1];
  assign sda_s      = sda_sh[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_ee_addr_dec.sv
module i2c_ee_addr_dec
  import i2c_ee_pkg::*;
#(
  parameter int BLK_W  = 1,
  parameter int BLKO_W = 1
) (
  input  logic [6:0]        dev_i,   // slave byte bits 7..1
  input  logic [2:0]        pins_i,
  output logic              match_o,
  output logic [BLKO_W-1:0] blk_o
);

  localparam logic [2:0] PIN_MASK = 3'(3'b111 << BLK_W);

  assign match_o = (dev_i[6:3] == DEV_TYPE) &&
                   (((dev_i[2:0] ^ pins_i) & PIN_MASK) == 3'b000);

  generate
    if (BLK_W > 0) begin : g_blk
      assign blk_o = dev_i[BLK_W-1:0];
    end else begin : g_noblk
      assign blk_o = '0;
    end
  endgenerate

endmodule

// File: rtl/i2c_ee_mem.sv
module i2c_ee_mem #(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import i2c_ee_pkg::*;
#(
  parameter int DENSITY_KBIT = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] addr_pins_i,
  input  logic       wp_i
);

  localparam int BLK_W  = blk_bits(DENSITY_KBIT);
  localparam int DEPTH  = DENSITY_KBIT * 128;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int WORD_W = ADDR_W - BLK_W;
  localparam int BLKO_W = (BLK_W > 0) ? BLK_W : 1;

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic dev_match;
  logic [BLKO_W-1:0] dec_blk;

  ee_state_e         st_q;
  logic [3:0]        cnt_q;
  logic [7:0]        shreg_q, obyte_q;
  logic              oe_q, rw_q, mack_q;
  logic [ADDR_W-1:0] addr_q, addr_with_blk, addr_with_word, addr_inc;
  logic [7:0]        rd_data;
  logic              mem_we, rx_phase;

  i2c_ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_ee_addr_dec #(.BLK_W(BLK_W), .BLKO_W(BLKO_W)) u_dec (
    .dev_i   (shreg_q[7:1]),
    .pins_i  (addr_pins_i),
    .match_o (dev_match),
    .blk_o   (dec_blk)
  );

  i2c_ee_mem #(.DEPTH(DEPTH), .AW(ADDR_W)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .addr_i  (addr_q),
    .wdata_i (shreg_q),
    .rdata_o (rd_data)
  );

  // pointer arithmetic stays inside the selected block
  generate
    if (BLK_W > 0) begin : g_blk
      assign addr_with_blk  = {dec_blk, addr_q[WORD_W-1:0]};
      assign addr_with_word = {addr_q[ADDR_W-1:WORD_W], shreg_q[WORD_W-1:0]};
      assign addr_inc       = {addr_q[ADDR_W-1:WORD_W], addr_q[WORD_W-1:0] + 1'b1};
    end else begin : g_flat
      assign addr_with_blk  = addr_q;
      assign addr_with_word = shreg_q[WORD_W-1:0];
      assign addr_inc       = addr_q + 1'b1;
    end
  endgenerate

  assign rx_phase = (st_q == ST_DEV) || (st_q == ST_WADDR) || (st_q == ST_WDATA);
  assign mem_we   = scl_fall && (st_q == ST_WDATA) && (cnt_q == 4'd8) && !wp_i;
  assign sda_oe_o = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      shreg_q <= '0;
      obyte_q <= '0;
      oe_q    <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      addr_q  <= '0;
    end else if (start_det) begin
      st_q  <= ST_DEV;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else if (stop_det) begin
      st_q <= ST_IDLE;
      oe_q <= 1'b0;
    end else begin
      if (scl_rise && rx_phase) begin
        shreg_q <= {shreg_q[6:0], sda_s};
        cnt_q   <= cnt_q + 4'd1;
      end
      if (scl_rise && st_q == ST_RDATA) cnt_q <= cnt_q + 4'd1;
      if (scl_rise && st_q == ST_RACK)  mack_q <= ~sda_s;
      if (scl_fall) begin
        case (st_q)
          ST_DEV: if (cnt_q == 4'd8) begin
            if (dev_match) begin
              st_q   <= ST_DEV_ACK;
              oe_q   <= 1'b1;
              rw_q   <= shreg_q[0];
              addr_q <= addr_with_blk;
            end else begin
              st_q <= ST_IDLE;
            end
          end
          ST_WADDR: if (cnt_q == 4'd8) begin
            addr_q <= addr_with_word;
            oe_q   <= 1'b1;
            st_q   <= ST_WADDR_ACK;
          end
          ST_WDATA: if (cnt_q == 4'd8) begin
            addr_q <= addr_inc;
            oe_q   <= 1'b1;
            st_q   <= ST_WDATA_ACK;
          end
          ST_DEV_ACK: begin
            cnt_q <= '0;
            if (rw_q) begin
              obyte_q <= rd_data;
              oe_q    <= ~rd_data[7];
              st_q    <= ST_RDATA;
            end else begin
              oe_q <= 1'b0;
              st_q <= ST_WADDR;
            end
          end
          ST_WADDR_ACK, ST_WDATA_ACK: begin
            cnt_q <= '0;
            oe_q  <= 1'b0;
            st_q  <= ST_WDATA;
          end
          ST_RDATA: begin
            if (cnt_q == 4'd8) begin
              cnt_q  <= '0;
              oe_q   <= 1'b0;
              addr_q <= addr_inc;
              st_q   <= ST_RACK;
            end else begin
              obyte_q <= {obyte_q[6:0], 1'b0};
              oe_q    <= ~obyte_q[6];
            end
          end
          ST_RACK: begin
            if (mack_q) begin
              obyte_q <= rd_data;
              oe_q    <= ~rd_data[7];
              st_q    <= ST_RDATA;
            end else begin
              st_q <= ST_WAIT;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_eeprom_slave_sva.sv
module i2c_eeprom_slave_sva
  import i2c_ee_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      scl_i,
  input logic      sda_oe_o,
  input ee_state_e st_i,
  input logic [3:0] cnt_i,
  input logic      mem_we_i,
  input logic      stop_i
);

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE) |-> !sda_oe_o);

  assert_stop_to_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (st_i == ST_IDLE) && !sda_oe_o);

  assert_drive_start_point_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> (st_i inside {ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK, ST_RDATA}));

  assert_bitcnt_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= 4'd8);

  assert_store_then_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |=> (st_i == ST_WDATA_ACK) && sda_oe_o);

  // SCL held high for four samples: the driven level must not move
  assert_oe_stable_scl_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && $past(scl_i) && $past(scl_i, 2) && $past(scl_i, 3)) |-> $stable(sda_oe_o));

endmodule

bind i2c_eeprom_slave i2c_eeprom_slave_sva u_sva (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_i    (scl_i),
  .sda_oe_o (sda_oe_o),
  .st_i     (st_q),
  .cnt_i    (cnt_q),
  .mem_we_i (mem_we),
  .stop_i   (stop_det)
);

// File: tb/i2c_eeprom_slave_bench.sv
module i2c_eeprom_slave_bench;

  localparam int H = 16;  // SCL half period in system clocks

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic wp = 1'b0;
  logic [2:0] pins = 3'b010;
  logic sda_oe;
  logic sda_bus;

  int total = 0;
  int passed = 0;

  always #4 clk = ~clk;

  assign sda_bus = m_sda & ~sda_oe;

  i2c_eeprom_slave u_i2c_eeprom_slave (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (m_scl),
    .sda_i       (sda_bus),
    .sda_oe_o    (sda_oe),
    .addr_pins_i (pins),
    .wp_i        (wp)
  );

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (ok) passed++;
    else $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
  endtask

  function automatic logic [7:0] dev(input logic blk, input logic rd);
    return {4'b1010, 1'b0, 1'b1, blk, rd};
  endfunction

  task automatic bus_start();
    m_sda = 1'b1; wclk(H/2);
    m_scl = 1'b1; wclk(H);
    m_sda = 1'b0; wclk(H);
    m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    wclk(H/2); m_sda = 1'b0;
    wclk(H/2); m_scl = 1'b1;
    wclk(H);   m_sda = 1'b1;
    wclk(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack, output logic rel);
    for (int i = 7; i >= 0; i--) begin
      wclk(H/2); m_sda = b[i];
      wclk(H/2); m_scl = 1'b1;
      wclk(H);   m_scl = 1'b0;
    end
    wclk(H/2); m_sda = 1'b1;
    wclk(H/2); m_scl = 1'b1;
    wclk(H/2); ack = !sda_bus;
    wclk(H/2); m_scl = 1'b0;
    wclk(H/2); rel = !sda_oe;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b, output logic stable);
    logic s1;
    stable = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wclk(H/2); m_sda = 1'b1;
      wclk(H/2); m_scl = 1'b1;
      wclk(H/4); s1 = sda_bus;
      wclk(H/2); if (sda_bus !== s1) stable = 1'b0;
      wclk(H/4); m_scl = 1'b0;
      b = {b[6:0], s1};
    end
    wclk(H/2); m_sda = ack ? 1'b0 : 1'b1;
    wclk(H/2); m_scl = 1'b1;
    wclk(H);   m_scl = 1'b0;
  endtask

  task automatic do_write(input logic blk, input logic [7:0] word, input logic [31:0] data,
                          input int n, output logic all_ack);
    logic a, r;
    all_ack = 1'b1;
    bus_start();
    send_byte(dev(blk, 1'b0), a, r); all_ack &= a;
    send_byte(word, a, r);           all_ack &= a;
    for (int i = 0; i < n; i++) begin
      send_byte(data[8*(n-1-i) +: 8], a, r);
      all_ack &= a;
    end
    bus_stop();
  endtask

  task automatic rand_read(input logic blk, input logic [7:0] word, input int n,
                           output logic [31:0] got, output logic stable);
    logic a, r, st;
    logic [7:0] b;
    got = '0;
    stable = 1'b1;
    bus_start();
    send_byte(dev(blk, 1'b0), a, r);
    send_byte(word, a, r);
    bus_start();
    send_byte(dev(blk, 1'b1), a, r);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n-1, b, st);
      got = {got[23:0], b};
      stable &= st;
    end
    bus_stop();
  endtask

  task automatic t_reset();
    logic a, r;
    check(sda_oe == 1'b0, "R1", "sda_oe after reset", {31'b0, sda_oe}, 0);
    wclk(H); m_scl = 1'b0;
    send_byte(dev(1'b0, 1'b0), a, r);
    check(a == 1'b0, "R1", "ack without START", {31'b0, a}, 0);
    bus_stop();
  endtask

  task automatic t_addr_match();
    logic a, r;
    bus_start(); send_byte(8'hB4, a, r); bus_stop();
    check(a == 1'b0, "R3", "wrong device type ack", {31'b0, a}, 0);
    bus_start(); send_byte(8'hAC, a, r); bus_stop();
    check(a == 1'b0, "R4", "pin mismatch ack", {31'b0, a}, 0);
    bus_start(); send_byte(dev(1'b0, 1'b0), a, r); bus_stop();
    check(a == 1'b1, "R4", "pin match ack", {31'b0, a}, 1);
    bus_start(); send_byte(dev(1'b1, 1'b0), a, r); bus_stop();
    check(a == 1'b1, "R7", "block bit ignored by match", {31'b0, a}, 1);
  endtask

  task automatic t_ack_timing();
    logic a, r;
    bus_start(); send_byte(dev(1'b0, 1'b0), a, r); bus_stop();
    check(a && r, "R5", "ack held in 9th pulse then released", {30'b0, a, r}, 3);
  endtask

  task automatic t_erased();
    logic [31:0] got;
    logic st;
    rand_read(1'b0, 8'h10, 1, got, st);
    check(got[7:0] == 8'hFF, "R10", "erased byte", got, 32'hFF);
  endtask

  task automatic t_write_wrap();
    logic ok, st;
    logic [31:0] got;
    logic [7:0] b;
    logic a, r;
    do_write(1'b0, 8'hFE, 32'hA1A2A3A4, 4, ok);
    check(ok, "R6", "write transfer acks", {31'b0, ok}, 1);
    rand_read(1'b0, 8'hFE, 3, got, st);
    check(got[23:0] == 24'hA1A2A3, "R6", "sequential write wrap", got, 32'hA1A2A3);
    check(st, "R9", "read data stable while SCL high", {31'b0, st}, 1);
    bus_start();
    send_byte(dev(1'b0, 1'b1), a, r);
    recv_byte(1'b0, b, st);
    bus_stop();
    check(b == 8'hA4, "R11", "current address read", {24'b0, b}, 32'hA4);
    rand_read(1'b1, 8'h00, 1, got, st);
    check(got[7:0] == 8'hFF, "R6", "wrap stayed in block 0", got, 32'hFF);
  endtask

  task automatic t_block();
    logic ok, st;
    logic [31:0] got;
    do_write(1'b1, 8'h05, 32'h5A, 1, ok);
    rand_read(1'b1, 8'h05, 1, got, st);
    check(got[7:0] == 8'h5A, "R7", "block 1 readback", got, 32'h5A);
    rand_read(1'b0, 8'h05, 1, got, st);
    check(got[7:0] == 8'hFF, "R7", "block 0 untouched", got, 32'hFF);
  endtask

  task automatic t_wp();
    logic ok, st;
    logic [31:0] got;
    wp = 1'b1;
    do_write(1'b0, 8'h20, 32'h33, 1, ok);
    wp = 1'b0;
    check(ok, "R8", "protected write still acked", {31'b0, ok}, 1);
    rand_read(1'b0, 8'h20, 1, got, st);
    check(got[7:0] == 8'hFF, "R8", "protected byte unchanged", got, 32'hFF);
  endtask

  task automatic t_stop_idle();
    logic a, r;
    bus_start(); send_byte(dev(1'b0, 1'b0), a, r); bus_stop();
    wclk(H); m_scl = 1'b0;
    send_byte(dev(1'b0, 1'b0), a, r);
    check(a == 1'b0, "R2", "ack after STOP without START", {31'b0, a}, 0);
    bus_stop();
  endtask

  task automatic t_nack();
    logic ok, a, r, st;
    logic [7:0] b;
    logic seen;
    do_write(1'b0, 8'h40, 32'h1234, 2, ok);
    bus_start();
    send_byte(dev(1'b0, 1'b0), a, r);
    send_byte(8'h40, a, r);
    bus_start();
    send_byte(dev(1'b0, 1'b1), a, r);
    recv_byte(1'b0, b, st);
    check(b == 8'h12, "R9", "first read byte", {24'b0, b}, 32'h12);
    seen = 1'b0;
    for (int i = 0; i < H; i++) begin
      wclk(1);
      seen |= sda_oe;
    end
    check(!seen, "R9", "SDA released after NACK", {31'b0, seen}, 0);
    bus_stop();
  endtask

  initial begin
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    t_reset();
    t_addr_match();
    t_ack_timing();
    t_erased();
    t_write_wrap();
    t_block();
    t_wp();
    t_stop_idle();
    t_nack();
    wclk(10);
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    $display("FAIL R1 watchdog: actual=timeout expected=done");
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

endmodule